// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one 16-bit down-counting timer channel behind a byte-wide write bus. Software first writes a control byte to address 3, which picks the waveform mode. It then writes a 16-bit divisor to address 0 as two byte writes, low byte first. From the following clock the channel divides its input clock by that divisor. The output `wave_out` repeats once per divisor period, and its edges can be used as a periodic interrupt request.

Two waveforms are available, both counted in plain binary:
- **Square wave.** The output is high for the first half of each period. With an odd divisor the high part is one clock longer than the low part.
- **Rate generator.** The output drops low for a single clock at the end of each period.

Other control bytes are ignored. A divisor of zero stands for 65536. The divisor and the mode chosen by the control byte take effect together, only when the high byte is written. Until then, the waveform already running goes on unchanged.

Top module: `pit_timer`

## Requirements
- R1: After reset `wave_out` is high. It stays high, with the channel idle, until the first high byte of a divisor is written. At reset the pending mode is square wave.
- R2: A write to address 3 is accepted only if all of the following hold:
  - bits 7:6 are 00;
  - bits 5:4 are 11;
  - bit 0 is 0;
  - bits 3:1 are 010 (rate generator) or 011 (square wave).

  Any other control byte changes neither the pending mode nor the byte pointer.
- R3: An accepted control byte resets the byte pointer. Writes to address 0 then alternate: the first is the low byte, the second is the high byte.
- R4: A high-byte write loads the divisor and the pending mode. The new period starts on the next clock with the output high. Before that write, the running waveform continues unchanged.
- R5: In square-wave mode with an even divisor N, the output is high for N/2 clocks and then low for N/2 clocks, repeating every N clocks.
- R6: In square-wave mode with an odd divisor N, the output is high for (N+1)/2 clocks and then low for (N-1)/2 clocks.
- R7: In rate-generator mode with divisor N ≥ 2, the output is high for N-1 clocks and then low for exactly one clock, repeating every N clocks.
- R8: A divisor of 0 is counted as 65536. In square-wave mode this gives 32768 high clocks and then 32768 low clocks.
- R9: Writes to addresses 1 and 2 have no effect.
- R10: A high-byte write in the last clock of a period takes priority over the natural wrap. The next period uses the new divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that is divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 2 | Write address (0 = divisor data, 3 = control) |
| wdata | input | 8 | Write data byte |
| wave_out | output | 1 | Divided waveform / periodic request |

## Verification
Two events can fall on the same clock: the reload caused by a high-byte write, and the counter's own wrap at the end of a period. The bench provokes this with a low byte already written. It then watches the rate-generator output until the single low clock appears, and presents the high byte in exactly that cycle. The result is judged by comparing the following clocks against the pattern for the new divisor, counted from the write. If the wrap had won instead, the old period length would show.

// File: rtl/pit_timer.sv
module pit_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic       wave_out
);
  localparam int DW = 16;
  localparam int CW = DW + 1;
  localparam logic [CW-1:0] FULL = CW'(1) << DW;

  logic          byte_hi;
  logic [7:0]    lo_q;
  logic          pend_sq;
  logic          act_sq;
  logic          running;
  logic [CW-1:0] div_q;
  logic [CW-1:0] ph;

  wire ctrl_ok = wr_en && addr == 2'd3 && wdata[7:6] == 2'b00 &&
                 wdata[5:4] == 2'b11 && !wdata[0] &&
                 (wdata[3:1] == 3'b010 || wdata[3:1] == 3'b011);
  wire data_wr = wr_en && addr == 2'd0;
  wire load    = data_wr && byte_hi;

  wire [DW-1:0] raw     = {wdata, lo_q};
  wire [CW-1:0] new_div = (raw == '0) ? FULL : {1'b0, raw};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_hi <= 1'b0;
      lo_q    <= '0;
      pend_sq <= 1'b1;
      act_sq  <= 1'b1;
      running <= 1'b0;
      div_q   <= FULL;
      ph      <= CW'(1);
    end else begin
      if (running)
        ph <= (ph == CW'(1)) ? div_q : ph - CW'(1);
      if (ctrl_ok) begin
        byte_hi <= 1'b0;
        pend_sq <= wdata[1];
      end else if (data_wr) begin
        if (!byte_hi) begin
          lo_q    <= wdata;
          byte_hi <= 1'b1;
        end else begin
          byte_hi <= 1'b0;
          div_q   <= new_div;
          ph      <= new_div;
          act_sq  <= pend_sq;
          running <= 1'b1;
        end
      end
    end
  end

  assign wave_out = !running ||
                    (act_sq ? (ph > (div_q >> 1)) : (ph != CW'(1)));
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  addr,
  input logic [7:0]  wdata,
  input logic        wave_out,
  input logic        byte_hi,
  input logic        pend_sq,
  input logic        act_sq,
  input logic        running,
  input logic [16:0] div_q,
  input logic [16:0] ph,
  input logic [7:0]  lo_q
);
  wire good_ctrl = wr_en && addr == 2'd3 && wdata[7:6] == 2'b00 &&
                   wdata[5:4] == 2'b11 && !wdata[0] &&
                   (wdata[3:1] == 3'b010 || wdata[3:1] == 3'b011);
  wire bad_ctrl  = wr_en && addr == 2'd3 && !good_ctrl;
  wire hi_load   = wr_en && addr == 2'd0 && byte_hi;

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> wave_out);

  assert_bad_ctrl_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bad_ctrl |=> $stable(byte_hi) && $stable(pend_sq));

  assert_ptr_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    good_ctrl |=> !byte_hi);

  assert_load_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hi_load |=> running && wave_out && ph == div_q &&
                div_q[15:0] == {$past(wdata), $past(lo_q)});

  assert_zero_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> ph >= 17'd1 && ph <= div_q && div_q != 17'd0);

  assert_rate_one_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !act_sq && !wave_out && div_q != 17'd1 && !hi_load) |=> wave_out);

  assert_other_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == 2'd1 || addr == 2'd2)) |=> $stable(byte_hi) && $stable(div_q));
endmodule

bind pit_timer pit_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .wave_out(wave_out), .byte_hi(byte_hi), .pend_sq(pend_sq), .act_sq(act_sq),
  .running(running), .div_q(div_q), .ph(ph), .lo_q(lo_q)
);

// File: tb/sim_pit_timer.sv
`timescale 1ns/1ps
module sim_pit_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic wave_out;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pit_timer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                .wdata(wdata), .wave_out(wave_out));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd0; wdata = 8'd0;
  endtask

  task automatic load(input logic [7:0] ctrl, input int n);
    wr(2'd3, ctrl);
    wr(2'd0, n[7:0]);
    wr(2'd0, n[15:8]);
  endtask

  task automatic expect_wave(input string req, input int n, input bit sq, input int periods);
    int bad = 0;
    int first_i = -1;
    for (int i = 0; i < n * periods; i++) begin
      int p = i % n;
      bit e = sq ? (p < (n + 1) / 2) : (p < n - 1);
      if (wave_out !== e) begin
        bad++;
        if (first_i < 0) first_i = i;
      end
      @(negedge clk);
    end
    chk(bad == 0, req, bad, 0);
    if (bad != 0) $display("  first mismatch at clock %0d (n=%0d)", first_i, n);
  endtask

  task automatic count_high(input string req, input int cycles, input int exp);
    int h = 0;
    for (int i = 0; i < cycles; i++) begin
      if (wave_out) h++;
      @(negedge clk);
    end
    chk(h == exp, req, h, exp);
  endtask

  task automatic t_reset();
    chk(wave_out === 1'b1, "R1 reset high", wave_out, 1);
    wr(2'd0, 8'd3);
    count_high("R1 idle after low byte only", 10, 10);
    wr(2'd3, 8'h36);
  endtask

  task automatic t_square();
    load(8'h36, 6);  expect_wave("R5 square even 6", 6, 1'b1, 3);
    load(8'h36, 2);  expect_wave("R5 square even 2", 2, 1'b1, 4);
    load(8'h36, 7);  expect_wave("R6 square odd 7", 7, 1'b1, 3);
    load(8'h36, 3);  expect_wave("R6 square odd 3", 3, 1'b1, 4);
  endtask

  task automatic t_rate();
    load(8'h34, 5);  expect_wave("R7 rate 5", 5, 1'b0, 3);
    load(8'h34, 2);  expect_wave("R7 rate 2", 2, 1'b0, 4);
    load(8'h34, 300); expect_wave("R7 rate 300 two-byte", 300, 1'b0, 2);
  endtask

  task automatic t_ignored();
    load(8'h36, 4);
    wr(2'd0, 8'd10);
    count_high("R4 old wave continues", 8, 4);
    wr(2'd3, 8'h35);
    wr(2'd3, 8'h74);
    wr(2'd3, 8'h14);
    wr(2'd3, 8'h32);
    wr(2'd1, 8'h55);
    wr(2'd2, 8'h55);
    count_high("R9 no effect of addr 1/2", 8, 4);
    wr(2'd0, 8'd0);
    expect_wave("R2 ignored ctrl keeps ptr and mode", 10, 1'b1, 2);
  endtask

  task automatic t_ptr_reset();
    wr(2'd0, 8'd3);
    wr(2'd3, 8'h34);
    wr(2'd0, 8'd5);
    wr(2'd0, 8'd0);
    expect_wave("R3 ctrl resets byte pointer", 5, 1'b0, 3);
  endtask

  task automatic t_collision();
    load(8'h34, 5);
    wr(2'd0, 8'd6);
    while (wave_out) @(negedge clk);
    wr(2'd0, 8'd0);
    expect_wave("R10 reload wins over wrap", 6, 1'b0, 3);
  endtask

  task automatic t_zero();
    load(8'h36, 0);
    expect_wave("R8 divisor zero is 65536", 65536, 1'b1, 1);
    chk(wave_out === 1'b1, "R8 next period high", wave_out, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_square();
    t_rate();
    t_ignored();
    t_ptr_reset();
    t_collision();
    t_zero();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #760000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule